// File: doc/BRIEF.md
# Synchronous Phase-Frequency Detector with Charge-Pump Overrides

This block compares the timing of a reference clock and a feedback clock and turns the difference into digital pump-up and pump-down commands for a charge pump. Both inputs are sampled by a faster system clock. A rising edge on either input, seen after synchronization, is an event. A reference event sets the up state flop. A feedback event sets the down state flop. When both flops are set, they clear together after a reset delay that software can select.

Several control inputs shape the commands. One swaps the roles of the two inputs. One holds the detector in reset. Two force source or sink current continuously. One stretches the reset delay so that the minimum pulses are wider. Two comparator inputs report that the pump output voltage is too high or too low. When the matching clamp is enabled, each comparator suppresses the corresponding command and raises a status flag. Holding the detector in reset while forcing one direction precharges the loop filter to a known level.

Top module: `pfd_pump_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, both detector state flops are cleared. After reset, with no override active, `pump_up` and `pump_dn` are 0.
- R2: In normal mode, a 0-to-1 change on `ref_clk` sets `pump_up` and a 0-to-1 change on `fb_clk` sets `pump_dn`. If the input changes before clock edge k, the output is 1 after edge k+2 and still 0 after edge k+1.
- R3: With `wide_pulse` = 0, both flops are set together for exactly 1 clock cycle and then both clear.
- R4: With `wide_pulse` = 1, both flops are set together for exactly 4 clock cycles and then both clear.
- R5: With `phase_inv` = 1, a `ref_clk` edge sets `pump_dn` and a `fb_clk` edge sets `pump_up`.
- R6: While `pfd_hold` = 1, both state flops stay cleared, and input edges have no effect on `pump_up` or `pump_dn`.
- R7: `src_force` = 1 drives `pump_up` to 1 in the same cycle, whatever the detector state. This includes the case where `pfd_hold` = 1 (precharge).
- R8: `snk_force` = 1 drives `pump_dn` to 1 in the same cycle, whatever the detector state. This includes the case where `pfd_hold` = 1.
- R9: With `src_force` and `snk_force` both set, both outputs are 1, and clamp gating still applies to each of them separately.
- R10: With `hi_clamp_en` = 1 and `v_too_high` = 1, `hi_clamp_flag` is 1 and `pump_up` is 0. This holds whether `pump_up` comes from the detector or from a force.
- R11: With `lo_clamp_en` = 1 and `v_too_low` = 1, `lo_clamp_flag` is 1 and `pump_dn` is 0.
- R12: A clamp flag equals its comparator input while its clamp is enabled. It is 0 while its clamp is disabled, and a disabled clamp does not gate its command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_clk | input | 1 | Reference input (asynchronous) |
| fb_clk | input | 1 | Feedback input (asynchronous) |
| phase_inv | input | 1 | Swap reference and feedback roles |
| pfd_hold | input | 1 | Hold detector state flops cleared |
| src_force | input | 1 | Force continuous up command |
| snk_force | input | 1 | Force continuous down command |
| wide_pulse | input | 1 | Select long reset delay |
| hi_clamp_en | input | 1 | Enable high-voltage clamp |
| lo_clamp_en | input | 1 | Enable low-voltage clamp |
| v_too_high | input | 1 | Comparator: pump output too high |
| v_too_low | input | 1 | Comparator: pump output too low |
| pump_up | output | 1 | Gated source command |
| pump_dn | output | 1 | Gated sink command |
| hi_clamp_flag | output | 1 | High clamp active |
| lo_clamp_flag | output | 1 | Low clamp active |

## Verification
The checker enforces the following on every cycle:
- reset and hold clearing of the state flops;
- the one-cycle overlap in normal mode;
- force and clamp gating at the outputs;
- the flags reading zero while their clamp is disabled.

Other behaviours involve a sequence of input edges, so only the directed scenarios can show them:
- the three-edge latency from an input change to a command;
- the four-cycle overlap in wide mode;
- the role swap under inversion;
- the precharge combination of hold with a force.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
   // Pair of pump commands moving between detector and output gate.
   typedef struct packed {
      logic up;
      logic dn;
   } pump_cmd_t;

   // Clamp configuration and comparator readings for one direction.
   typedef struct packed {
      logic en;
      logic hit;
   } clamp_in_t;
endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("pfd_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], async_in};
         prev_q <= sync_q[LAST];
      end
   end

   assign rise = sync_q[LAST] & ~prev_q;
endmodule

// File: rtl/pfd_detector.sv
module pfd_detector
   import pfd_pkg::*;
#(
   parameter int DLY_NORM = 1,
   parameter int DLY_WIDE = 4
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      ev_lead,
   input  logic      ev_lag,
   input  logic      hold,
   input  logic      wide,
   output pump_cmd_t state
);
   localparam int MAX_DLY = (DLY_WIDE > DLY_NORM) ? DLY_WIDE : DLY_NORM;
   localparam int CNT_W   = (MAX_DLY > 1) ? $clog2(MAX_DLY) : 1;

   if (DLY_NORM < 1 || DLY_WIDE < 1) begin : g_bad_dly
      $error("pfd_detector: reset delays must be at least one cycle");
   end

   logic up_q, dn_q;
   logic both_set;
   logic rst_hit;

   assign both_set = up_q & dn_q;

   if (MAX_DLY == 1) begin : g_no_cnt
      // Every delay is one cycle: clear on the edge after overlap.
      assign rst_hit = both_set;
   end else begin : g_cnt
      localparam logic [CNT_W-1:0] LIM_N = CNT_W'(DLY_NORM - 1);
      localparam logic [CNT_W-1:0] LIM_W = CNT_W'(DLY_WIDE - 1);
      logic [CNT_W-1:0] cnt_q;
      logic [CNT_W-1:0] lim;

      assign lim     = wide ? LIM_W : LIM_N;
      assign rst_hit = both_set && (cnt_q >= lim);

      always_ff @(posedge clk) begin
         if (!rst_n || hold || rst_hit || !both_set) begin
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || hold) begin
         up_q <= 1'b0;
         dn_q <= 1'b0;
      end else if (rst_hit) begin
         up_q <= 1'b0;
         dn_q <= 1'b0;
      end else begin
         if (ev_lead) up_q <= 1'b1;
         if (ev_lag)  dn_q <= 1'b1;
      end
   end

   assign state.up = up_q;
   assign state.dn = dn_q;
endmodule

// File: rtl/pfd_pump_gate.sv
module pfd_pump_gate
   import pfd_pkg::*;
(
   input  pump_cmd_t det,
   input  logic      force_up,
   input  logic      force_dn,
   input  clamp_in_t hi,
   input  clamp_in_t lo,
   output pump_cmd_t cmd,
   output logic      hi_flag,
   output logic      lo_flag
);
   logic hi_block, lo_block;

   assign hi_block = hi.en & hi.hit;
   assign lo_block = lo.en & lo.hit;

   assign cmd.up  = (det.up | force_up) & ~hi_block;
   assign cmd.dn  = (det.dn | force_dn) & ~lo_block;
   assign hi_flag = hi_block;
   assign lo_flag = lo_block;
endmodule

// File: rtl/pfd_pump_ctrl.sv
module pfd_pump_ctrl
   import pfd_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int DLY_NORM    = 1,
   parameter int DLY_WIDE    = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_clk,
   input  logic fb_clk,
   input  logic phase_inv,
   input  logic pfd_hold,
   input  logic src_force,
   input  logic snk_force,
   input  logic wide_pulse,
   input  logic hi_clamp_en,
   input  logic lo_clamp_en,
   input  logic v_too_high,
   input  logic v_too_low,
   output logic pump_up,
   output logic pump_dn,
   output logic hi_clamp_flag,
   output logic lo_clamp_flag
);
   localparam int N_IN = 2;

   logic [N_IN-1:0] raw_in;
   logic [N_IN-1:0] rise;
   logic            ev_lead, ev_lag;
   pump_cmd_t       det_state;
   pump_cmd_t       gated;
   clamp_in_t       hi_cfg, lo_cfg;

   assign raw_in = {fb_clk, ref_clk};

   for (genvar i = 0; i < N_IN; i++) begin : g_sync
      pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk     (clk),
         .rst_n   (rst_n),
         .async_in(raw_in[i]),
         .rise    (rise[i])
      );
   end

   // Role swap: the inverted mode lets feedback drive the up flop.
   assign ev_lead = phase_inv ? rise[1] : rise[0];
   assign ev_lag  = phase_inv ? rise[0] : rise[1];

   pfd_detector #(.DLY_NORM(DLY_NORM), .DLY_WIDE(DLY_WIDE)) u_det (
      .clk    (clk),
      .rst_n  (rst_n),
      .ev_lead(ev_lead),
      .ev_lag (ev_lag),
      .hold   (pfd_hold),
      .wide   (wide_pulse),
      .state  (det_state)
   );

   assign hi_cfg = '{en: hi_clamp_en, hit: v_too_high};
   assign lo_cfg = '{en: lo_clamp_en, hit: v_too_low};

   pfd_pump_gate u_gate (
      .det     (det_state),
      .force_up(src_force),
      .force_dn(snk_force),
      .hi      (hi_cfg),
      .lo      (lo_cfg),
      .cmd     (gated),
      .hi_flag (hi_clamp_flag),
      .lo_flag (lo_clamp_flag)
   );

   assign pump_up = gated.up;
   assign pump_dn = gated.dn;
endmodule

// File: rtl/pfd_pump_ctrl_chk.sv
module pfd_pump_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic pfd_hold,
   input logic src_force,
   input logic snk_force,
   input logic wide_pulse,
   input logic hi_clamp_en,
   input logic lo_clamp_en,
   input logic v_too_high,
   input logic v_too_low,
   input logic pump_up,
   input logic pump_dn,
   input logic hi_clamp_flag,
   input logic lo_clamp_flag,
   input logic st_up,
   input logic st_dn
);
   // R1: reset clears the state flops by the following cycle
   a_r1_reset_clears: assert property (@(posedge clk)
      !rst_n |=> (!st_up && !st_dn));

   // R6: holding the detector keeps its state flops cleared
   a_r6_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
      pfd_hold |=> (!st_up && !st_dn));

   // R3: in normal mode the overlap lasts a single cycle
   a_r3_single_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      (st_up && st_dn && !wide_pulse) |=> (!st_up && !st_dn));

   // R7: a forced source reaches the output unless clamped
   a_r7_force_up: assert property (@(posedge clk) disable iff (!rst_n)
      (src_force && !(hi_clamp_en && v_too_high)) |-> pump_up);

   // R8: a forced sink reaches the output unless clamped
   a_r8_force_dn: assert property (@(posedge clk) disable iff (!rst_n)
      (snk_force && !(lo_clamp_en && v_too_low)) |-> pump_dn);

   // R10: an active high clamp blocks sourcing and raises its flag
   a_r10_hi_clamp: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_clamp_en && v_too_high) |-> (!pump_up && hi_clamp_flag));

   // R11: an active low clamp blocks sinking and raises its flag
   a_r11_lo_clamp: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_clamp_en && v_too_low) |-> (!pump_dn && lo_clamp_flag));

   // R12: flags stay low while their clamp is disabled
   a_r12_flags_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!hi_clamp_en |-> !hi_clamp_flag) and (!lo_clamp_en |-> !lo_clamp_flag));
endmodule

bind pfd_pump_ctrl pfd_pump_ctrl_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .pfd_hold     (pfd_hold),
   .src_force    (src_force),
   .snk_force    (snk_force),
   .wide_pulse   (wide_pulse),
   .hi_clamp_en  (hi_clamp_en),
   .lo_clamp_en  (lo_clamp_en),
   .v_too_high   (v_too_high),
   .v_too_low    (v_too_low),
   .pump_up      (pump_up),
   .pump_dn      (pump_dn),
   .hi_clamp_flag(hi_clamp_flag),
   .lo_clamp_flag(lo_clamp_flag),
   .st_up        (det_state.up),
   .st_dn        (det_state.dn)
);

// File: tb/pfd_pump_ctrl_tb.sv
module pfd_pump_ctrl_tb;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n;
   logic ref_clk, fb_clk, phase_inv, pfd_hold, src_force, snk_force;
   logic wide_pulse, hi_clamp_en, lo_clamp_en, v_too_high, v_too_low;
   logic pump_up, pump_dn, hi_clamp_flag, lo_clamp_flag;

   int n_vec  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pfd_pump_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .fb_clk(fb_clk),
      .phase_inv(phase_inv), .pfd_hold(pfd_hold), .src_force(src_force),
      .snk_force(snk_force), .wide_pulse(wide_pulse),
      .hi_clamp_en(hi_clamp_en), .lo_clamp_en(lo_clamp_en),
      .v_too_high(v_too_high), .v_too_low(v_too_low),
      .pump_up(pump_up), .pump_dn(pump_dn),
      .hi_clamp_flag(hi_clamp_flag), .lo_clamp_flag(lo_clamp_flag)
   );

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic chk(input string req, input string what,
                      input logic got, input logic exp);
      n_vec++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b", req, what, got, exp);
      end
   endtask

   task automatic chk_out(input string req, input logic e_up, input logic e_dn);
      chk(req, "pump_up", pump_up, e_up);
      chk(req, "pump_dn", pump_dn, e_dn);
   endtask

   task automatic cleanup();
      ref_clk = 0; fb_clk = 0; phase_inv = 0; src_force = 0; snk_force = 0;
      wide_pulse = 0; hi_clamp_en = 0; lo_clamp_en = 0;
      v_too_high = 0; v_too_low = 0;
      pfd_hold = 1;
      tick(4);
      pfd_hold = 0;
      tick(1);
   endtask

   task automatic t_reset();
      chk_out("R1", 1'b0, 1'b0);
      chk("R1", "hi_flag", hi_clamp_flag, 1'b0);
      chk("R1", "lo_flag", lo_clamp_flag, 1'b0);
   endtask

   task automatic t_normal();
      ref_clk = 1;
      tick(2);
      chk_out("R2", 1'b0, 1'b0);
      tick(1);
      chk_out("R2", 1'b1, 1'b0);
      fb_clk = 1;
      tick(3);
      chk_out("R3", 1'b1, 1'b1);
      tick(1);
      chk_out("R3", 1'b0, 1'b0);
      tick(2);
      chk_out("R3", 1'b0, 1'b0);
      cleanup();
      fb_clk = 1;
      tick(3);
      chk_out("R2", 1'b0, 1'b1);
      cleanup();
   endtask

   task automatic t_wide();
      wide_pulse = 1;
      ref_clk = 1;
      tick(3);
      fb_clk = 1;
      tick(3);
      chk_out("R4", 1'b1, 1'b1);
      tick(3);
      chk_out("R4", 1'b1, 1'b1);
      tick(1);
      chk_out("R4", 1'b0, 1'b0);
      cleanup();
   endtask

   task automatic t_invert();
      phase_inv = 1;
      ref_clk = 1;
      tick(3);
      chk_out("R5", 1'b0, 1'b1);
      cleanup();
      phase_inv = 1;
      fb_clk = 1;
      tick(3);
      chk_out("R5", 1'b1, 1'b0);
      cleanup();
   endtask

   task automatic t_hold();
      pfd_hold = 1;
      ref_clk = 1;
      tick(3);
      chk_out("R6", 1'b0, 1'b0);
      fb_clk = 1;
      tick(4);
      chk_out("R6", 1'b0, 1'b0);
      cleanup();
   endtask

   task automatic t_force();
      src_force = 1; #1;
      chk_out("R7", 1'b1, 1'b0);
      pfd_hold = 1; tick(2);
      chk_out("R7", 1'b1, 1'b0);
      src_force = 0; snk_force = 1; #1;
      chk_out("R8", 1'b0, 1'b1);
      src_force = 1; #1;
      chk_out("R9", 1'b1, 1'b1);
      lo_clamp_en = 1; v_too_low = 1; #1;
      chk_out("R9", 1'b1, 1'b0);
      cleanup();
   endtask

   task automatic t_clamps();
      src_force = 1; hi_clamp_en = 1; v_too_high = 1; #1;
      chk("R10", "pump_up", pump_up, 1'b0);
      chk("R10", "hi_flag", hi_clamp_flag, 1'b1);
      v_too_high = 0; #1;
      chk("R12", "pump_up", pump_up, 1'b1);
      chk("R12", "hi_flag", hi_clamp_flag, 1'b0);
      hi_clamp_en = 0; v_too_high = 1; #1;
      chk("R12", "pump_up", pump_up, 1'b1);
      chk("R12", "hi_flag", hi_clamp_flag, 1'b0);
      cleanup();
      snk_force = 1; lo_clamp_en = 1; v_too_low = 1; #1;
      chk("R11", "pump_dn", pump_dn, 1'b0);
      chk("R11", "lo_flag", lo_clamp_flag, 1'b1);
      lo_clamp_en = 0; #1;
      chk("R12", "pump_dn", pump_dn, 1'b1);
      chk("R12", "lo_flag", lo_clamp_flag, 1'b0);
      cleanup();
      hi_clamp_en = 1; v_too_high = 1;
      ref_clk = 1;
      tick(3);
      chk("R10", "pump_up", pump_up, 1'b0);
      v_too_high = 0; #1;
      chk("R10", "pump_up", pump_up, 1'b1);
      cleanup();
   endtask

   initial begin
      rst_n = 0;
      ref_clk = 0; fb_clk = 0; phase_inv = 0; pfd_hold = 0;
      src_force = 0; snk_force = 0; wide_pulse = 0;
      hi_clamp_en = 0; lo_clamp_en = 0; v_too_high = 0; v_too_low = 0;
      tick(3);
      rst_n = 1;
      tick(1);
      t_reset();
      t_normal();
      t_wide();
      t_invert();
      t_hold();
      t_force();
      t_clamps();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end
endmodule